// File: doc/BRIEF.md
# Bit-Reversed Address Sequencer

This block produces the addresses used to reorder the data of a radix-2 FFT into bit-reversed order. A start pulse loads a base address, an index (normally half the number of points) and a point count. On each accepted step strobe, the address register is updated by adding or subtracting the index. The carry or borrow moves from the most significant bit toward the least significant bit, which is the reverse of a normal adder. When the base is aligned to the point count, repeated reverse-carry adds visit the points in bit-reversed order.

The current address is always visible on the output. A step makes the current value the address for that access, and the address for the next access appears one cycle later. A done flag rises once the programmed number of steps has been taken. After that, steps are ignored until the next start. The step direction is sampled on every step, so a sequence can be run backward with reverse-borrow subtraction.

Top module: `bitrev_addr_seq`

## Requirements
- R1: While reset is held and until the first start, addr_o is 0 and done_o is 1.
- R2: A start_i pulse captures base_i, index_i and npts_i. In the next cycle addr_o equals base_i and done_o is 1 only if npts_i was 0.
- R3: A step is accepted when step_i is 1, done_o is 0 and start_i is 0. addr_o keeps the current address in the cycle of the step and shows the updated address one cycle later.
- R4: With dir_i = 0, an accepted step sets the address to rev(rev(addr) + rev(index)) over 16 bits, where rev mirrors bit i to bit 15-i. The carry leaving bit 0 is dropped.
- R5: With dir_i = 1, an accepted step sets the address to rev(rev(addr) - rev(index)) modulo 2^16, with the borrow moving from bit 15 down to bit 0.
- R6: With index = N/2 and a base aligned to N (N a power of two), the address after k accepted add steps equals base + the low log2(N) bits of k mirrored.
- R7: done_o rises after npts accepted steps. While done_o is 1 and start_i is 0, step_i leaves addr_o unchanged and done_o stays 1.
- R8: start_i takes priority over step_i in the same cycle and restarts the step count.
- R9: Loading base + mirror(N-1) and stepping with dir_i = 1 yields the add sequence of R6 in reverse order.
- R10: With step_i and start_i both 0, addr_o holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load base, index and count; clear step count |
| base_i | input | ADDR_W | Base address loaded on start |
| index_i | input | ADDR_W | Index added or subtracted with reverse carry |
| npts_i | input | CNT_W | Number of steps before done |
| dir_i | input | 1 | 0 = reverse-carry add, 1 = reverse-borrow subtract |
| step_i | input | 1 | Step strobe |
| addr_o | output | ADDR_W | Current address |
| done_o | output | 1 | Programmed number of steps reached |

## Verification
On every cycle, the assertions check these properties against a mirror-add-mirror reference:
- the next address after an accepted step in either direction;
- that start loads the base address;
- that the address holds when idle;
- that done stays set and freezes the address.

Only the bench scenarios can show the sequence-level properties:
- that a full aligned 16-point run visits the bit-reversed order and ends with done;
- that a reverse-borrow run retraces that order backward;
- that a start issued mid-run wins over a simultaneous step.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
  typedef enum logic {
    DIR_ADD = 1'b0,
    DIR_SUB = 1'b1
  } step_dir_e;
endpackage

// File: rtl/rc_adder.sv
// Adder whose carry chain runs from MSB to LSB; sub_i selects two's-complement borrow.
module rc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_x;
  logic [W:1]   cy;

  assign b_x   = b_i ^ {W{sub_i}};
  assign cy[W] = sub_i;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_x[i] ^ cy[i+1];
    if (i > 0) begin : g_cy
      assign cy[i] = (a_i[i] & b_x[i]) | (cy[i+1] & (a_i[i] ^ b_x[i]));
    end
  end
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             adv_i,
  output logic             done_o
);
  logic [CNT_W-1:0] count_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (load_i) begin
      count_q <= '0;
      limit_q <= limit_i;
    end else if (adv_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign done_o = (count_q == limit_q);
endmodule

// File: rtl/bitrev_addr_seq.sv
module bitrev_addr_seq
  import bitrev_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [CNT_W-1:0]  npts_i,
  input  logic              dir_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q, idx_q, addr_nxt;
  logic              done, step_ok;
  step_dir_e         dir;

  assign dir     = step_dir_e'(dir_i);
  assign step_ok = step_i & ~done & ~start_i;

  rc_adder #(.W(ADDR_W)) i_rc_adder (
    .a_i  (addr_q),
    .b_i  (idx_q),
    .sub_i(dir == DIR_SUB),
    .sum_o(addr_nxt)
  );

  step_counter #(.CNT_W(CNT_W)) i_step_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .limit_i(npts_i),
    .adv_i  (step_ok),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      addr_q <= base_i;
      idx_q  <= index_i;
    end else if (step_ok) begin
      addr_q <= addr_nxt;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done;
endmodule

// File: rtl/bitrev_addr_seq_chk.sv
module bitrev_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [CNT_W-1:0]  npts_i,
  input logic              dir_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] idx_q
);
  function automatic logic [ADDR_W-1:0] mir(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
    return r;
  endfunction

  logic acc;
  assign acc = step_i && !done_o && !start_i;

  // R2
  load_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> addr_o == $past(base_i));

  // R2
  load_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o == ($past(npts_i) == '0));

  // R4
  rc_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !dir_i) |=> addr_o == mir(mir($past(addr_o)) + mir($past(idx_q))));

  // R5
  rc_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && dir_i) |=> addr_o == mir(mir($past(addr_o)) - mir($past(idx_q))));

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(addr_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step_i) |=> $stable(addr_o));
endmodule

bind bitrev_addr_seq bitrev_addr_seq_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .base_i (base_i),
  .npts_i (npts_i),
  .dir_i  (dir_i),
  .step_i (step_i),
  .addr_o (addr_o),
  .done_o (done_o),
  .idx_q  (idx_q)
);

// File: tb/test_bitrev_addr_seq.sv
`timescale 1ns/1ps
module test_bitrev_addr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] base_i = '0;
  logic [15:0] index_i = '0;
  logic [16:0] npts_i = '0;
  logic        dir_i = 1'b0;
  logic        step_i = 1'b0;
  logic [15:0] addr_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [15:0] addr;
    logic        done;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  bitrev_addr_seq i_bitrev_addr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .index_i(index_i), .npts_i(npts_i), .dir_i(dir_i), .step_i(step_i),
    .addr_o(addr_o), .done_o(done_o)
  );

  function automatic logic [15:0] rv(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction
  function automatic logic [15:0] rc_add(input logic [15:0] a, input logic [15:0] b);
    return rv(rv(a) + rv(b));
  endfunction
  function automatic logic [15:0] rc_sub(input logic [15:0] a, input logic [15:0] b);
    return rv(rv(a) - rv(b));
  endfunction
  function automatic logic [15:0] brk(input int k, input int bits);
    logic [15:0] r = '0;
    for (int i = 0; i < bits; i++) r[bits-1-i] = k[i];
    return r;
  endfunction

  task automatic check(input logic [15:0] a, input logic d, input exp_t e);
    n_chk++;
    if (a !== e.addr || d !== e.done) begin
      n_fail++;
      $display("FAIL %s: addr=%h done=%b expected addr=%h done=%b", e.tag, a, d, e.addr, e.done);
    end
  endtask

  // driver: one cycle of stimulus, expected post-edge outputs queued
  task automatic cyc(input logic st, input logic [15:0] b, input logic [15:0] ix,
                     input logic [16:0] np, input logic sp, input logic dr,
                     input logic [15:0] ea, input logic ed, input string tag);
    exp_t e;
    @(negedge clk_i);
    start_i = st; base_i = b; index_i = ix; npts_i = np; step_i = sp; dir_i = dr;
    e.addr = ea; e.done = ed; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) check(addr_o, done_o, sb_q.pop_front());
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: addr=%h done=%b expected completion", addr_o, done_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] cur;
    exp_t e0;
    #9;
    e0.addr = 16'h0; e0.done = 1'b1; e0.tag = "R1 reset";
    check(addr_o, done_o, e0);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 1, 0, 16'h0000, 1, "R1/R7 step before start ignored");

    // 16-point forward run, base aligned
    cyc(1, 16'h0100, 16'h0008, 17'd16, 0, 0, 16'h0100, 0, "R2 start load");
    cyc(0, 0, 0, 0, 0, 0, 16'h0100, 0, "R10 idle hold");
    for (int k = 1; k <= 16; k++)
      cyc(0, 0, 0, 0, 1, 0, 16'h0100 + brk(k % 16, 4), (k == 16), "R6/R3 bit-reversed add order");
    cyc(0, 0, 0, 0, 1, 0, 16'h0100, 1, "R7 step after done ignored");

    // reverse-borrow retrace
    cyc(1, 16'h0100 + brk(15, 4), 16'h0008, 17'd16, 0, 1, 16'h010F, 0, "R2 start load");
    for (int k = 1; k <= 15; k++)
      cyc(0, 0, 0, 0, 1, 1, 16'h0100 + brk(15 - k, 4), 0, "R9 subtract retraces");
    cyc(0, 0, 0, 0, 1, 1, 16'h010F, 1, "R5/R9 subtract wraps to top");

    // unaligned operands, mixed directions
    cur = 16'hA5C3;
    cyc(1, cur, 16'h1234, 17'd6, 0, 0, cur, 0, "R2 start load");
    for (int k = 0; k < 6; k++) begin
      logic d = k[0];
      cur = d ? rc_sub(cur, 16'h1234) : rc_add(cur, 16'h1234);
      cyc(0, 0, 0, 0, 1, d, cur, (k == 5), d ? "R5 reverse borrow" : "R4 reverse carry");
    end

    // carry past bit 0 dropped
    cyc(1, 16'h0001, 16'h0001, 17'd2, 0, 0, 16'h0001, 0, "R2 start load");
    cyc(0, 0, 0, 0, 1, 0, rc_add(16'h0001, 16'h0001), 0, "R4 carry out of bit 0 dropped");

    // start priority over step
    cyc(1, 16'h4000, 16'h0004, 17'd8, 1, 0, 16'h4000, 0, "R8 start wins over step");
    cyc(0, 0, 0, 0, 1, 0, 16'h4004, 0, "R8 count restarted, step taken");
    cyc(0, 0, 0, 0, 0, 0, 16'h4004, 0, "R10 idle hold");

    // zero points
    cyc(1, 16'h2222, 16'h0001, 17'd0, 0, 0, 16'h2222, 1, "R2 zero count done");
    cyc(0, 0, 0, 0, 1, 0, 16'h2222, 1, "R7 zero count step ignored");

    @(negedge clk_i);
    step_i = 0; start_i = 0;
    @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule